// File: doc/BRIEF.md
# Charge Gate Duty Window and Status Indicator

This block sits between a charger's mode controller and the external pass transistor of a single-cell nickel-metal-hydride charger. A hysteretic current comparator elsewhere reports, as one digital bit, whether the voltage on the sense resistor is below its regulation threshold. The block passes that bit to an active-low charge gate. It does so only while the present charger mode allows current to flow, which gives each mode its own average duty factor.

Mode timing is counted in base slots, each a parameterised number of clock cycles. Fast charge uses a 31-slot frame in which the last slot is blanked so that the cell can be measured with no current flowing. A strobe marks that slot. Precharge and top-off open 16 slots of a 64-slot frame, and maintenance opens one slot of it. A status line is steady or blinks at a mode-specific half-period. Any change of the mode input restarts both the duty frame and the blink phase, so the first window after a change is never cut short.

Top module: `chg_gate_status`

## Requirements
- R1: The output gate_n is active low. It is low exactly when the duty window of the present mode is open and sense_low is 1. It is high otherwise.
- R2: The mode encoding is 0 power-on reset, 1 suspend, 2 no cell, 3 precharge, 4 fast charge, 5 top-off, 6 maintenance and 7 fault. In modes 0, 1, 2 and 7, gate_n stays high whatever sense_low is.
- R3: In fast charge the slot index counts from 0 to FAST_SLOTS-1 (default 31) and then wraps. In slot FAST_SLOTS-1, gate_n is forced high and test_win is 1. In every other cycle, and in every other mode, test_win is 0.
- R4: In precharge and top-off the slot index counts from 0 to FRAME_SLOTS-1 (default 64) and then wraps. The window is open in slots 0 to PRE_ON_SLOTS-1 (default 16).
- R5: In maintenance the 64-slot frame opens only slots 0 to MAINT_ON_SLOTS-1 (default 1).
- R6: In precharge, status is a square wave with PRE_HALF cycles high and then PRE_HALF cycles low. It starts high in the first cycle of the mode.
- R7: In fault, status is a square wave with FAULT_HALF cycles per half. It starts high in the first cycle of the mode.
- R8: In fast charge (including the test slot) and in top-off, status is steady high.
- R9: In power-on reset, suspend, no cell and maintenance, status is low.
- R10: In the cycle in which the mode input takes a new value, the block is in cycle 0 of slot 0 of the new frame and in the first high half of any blink. Each slot lasts SLOT_CYC cycles.
- R11: While rst_n is low, gate_n is high and status and test_win are low, whatever the inputs are. After reset the block behaves as if it has been in power-on reset mode since cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Charger mode from the controller (encoding in R2) |
| sense_low | input | 1 | Comparator result: 1 when the sense voltage is below threshold |
| gate_n | output | 1 | Charge gate, active low |
| status | output | 1 | Status indicator |
| test_win | output | 1 | High during the fast-charge cell-test slot |

## Verification
The assertions check on every cycle the rules that do not depend on time. The gate never opens without the comparator asking for current. The gate stays shut in the blocking modes. The test strobe appears only in fast charge and with the gate shut. Status levels are fixed in the steady modes. Slot boundaries, the exact window widths of the 31- and 64-slot frames, the blink phases, and the restart at a mode change all depend on elapsed time. Only the bench's reference model shows them, as it counts the cycles since each mode change. It also covers a switch made mid-frame from a closed precharge slot into top-off.

// File: rtl/chg_gate_status.sv
module chg_gate_status #(
  parameter int SLOT_CYC       = 1000,
  parameter int FRAME_SLOTS    = 64,
  parameter int FAST_SLOTS     = 31,
  parameter int PRE_ON_SLOTS   = 16,
  parameter int MAINT_ON_SLOTS = 1,
  parameter int PRE_HALF       = 500,
  parameter int FAULT_HALF     = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       sense_low,
  output logic       gate_n,
  output logic       status,
  output logic       test_win
);
  localparam logic [2:0] M_PRE = 3'd3, M_FAST = 3'd4, M_TOP = 3'd5,
                         M_MAINT = 3'd6, M_FAULT = 3'd7;
  localparam int CW   = $clog2(SLOT_CYC);
  localparam int SW   = $clog2(FRAME_SLOTS);
  localparam int HMAX = (PRE_HALF > FAULT_HALF) ? PRE_HALF : FAULT_HALF;
  localparam int HW   = $clog2(HMAX);

  logic [2:0]    mode_q;
  logic [CW-1:0] cyc_q;
  logic [SW-1:0] slot_q;
  logic [HW-1:0] blk_q;
  logic          ph_q;

  wire           restart = (mode != mode_q);
  wire [CW-1:0]  cyc     = restart ? '0 : cyc_q;
  wire [SW-1:0]  slot    = restart ? '0 : slot_q;
  wire [HW-1:0]  blk     = restart ? '0 : blk_q;
  wire           ph      = restart ? 1'b1 : ph_q;

  wire           is_fast   = (mode == M_FAST);
  wire [SW-1:0]  last_slot = is_fast ? SW'(FAST_SLOTS - 1) : SW'(FRAME_SLOTS - 1);
  wire [HW-1:0]  half_m1   = (mode == M_FAULT) ? HW'(FAULT_HALF - 1) : HW'(PRE_HALF - 1);
  wire           cyc_wrap  = (cyc == CW'(SLOT_CYC - 1));
  wire           blk_wrap  = (blk == half_m1);
  wire           test_slot = is_fast && (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cyc_q  <= '0;
      slot_q <= '0;
      blk_q  <= '0;
      ph_q   <= 1'b1;
    end else begin
      mode_q <= mode;
      cyc_q  <= cyc_wrap ? '0 : cyc + 1'b1;
      if (cyc_wrap) slot_q <= (slot == last_slot) ? '0 : slot + 1'b1;
      else          slot_q <= slot;
      blk_q  <= blk_wrap ? '0 : blk + 1'b1;
      ph_q   <= blk_wrap ? ~ph : ph;
    end
  end

  logic win, stat_m;
  always_comb begin
    win    = 1'b0;
    stat_m = 1'b0;
    case (mode)
      M_PRE:   begin win = (slot < SW'(PRE_ON_SLOTS));   stat_m = ph;   end
      M_FAST:  begin win = !test_slot;                   stat_m = 1'b1; end
      M_TOP:   begin win = (slot < SW'(PRE_ON_SLOTS));   stat_m = 1'b1; end
      M_MAINT: begin win = (slot < SW'(MAINT_ON_SLOTS)); stat_m = 1'b0; end
      M_FAULT: begin win = 1'b0;                         stat_m = ph;   end
      default: begin win = 1'b0;                         stat_m = 1'b0; end
    endcase
  end

  assign gate_n   = !(rst_n && win && sense_low);
  assign status   = rst_n && stat_m;
  assign test_win = rst_n && test_slot;
endmodule

// File: rtl/chg_gate_status_chk.sv
module chg_gate_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       sense_low,
  input logic       gate_n,
  input logic       status,
  input logic       test_win
);
  p_gate_needs_cmp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |-> sense_low);

  p_gate_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd1 || mode == 3'd2 || mode == 3'd7) |-> gate_n);

  p_test_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_win |-> (gate_n && mode == 3'd4));

  p_status_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 || mode == 3'd5) |-> status);

  p_status_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd1 || mode == 3'd2 || mode == 3'd6) |-> !status);

  p_test_off_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd4) |-> !test_win);
endmodule

bind chg_gate_status chg_gate_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sense_low(sense_low),
  .gate_n(gate_n), .status(status), .test_win(test_win)
);

// File: tb/tb_chg_gate_status.sv
`timescale 1ns/1ps
module tb_chg_gate_status;
  localparam int SC = 4, PH = 6, FH = 3, FR = 64, FS = 31, PON = 16, MON = 1;

  logic clk = 1'b0, rst_n = 1'b0, sense_low = 1'b0;
  logic [2:0] mode = 3'd4;
  logic gate_n, status, test_win;
  int checks = 0, fails = 0, cur = 0, t = 0;

  always #5 clk = ~clk;

  chg_gate_status #(.SLOT_CYC(SC), .FRAME_SLOTS(FR), .FAST_SLOTS(FS),
    .PRE_ON_SLOTS(PON), .MAINT_ON_SLOTS(MON), .PRE_HALF(PH), .FAULT_HALF(FH))
  dut (.clk(clk), .rst_n(rst_n), .mode(mode), .sense_low(sense_low),
       .gate_n(gate_n), .status(status), .test_win(test_win));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d t=%0d actual=%b expected=%b", req, cur, t, act, exp);
    end
  endtask

  function automatic string gate_tag(input int m);
    string s;
    case (m)
      3: s = "R1 R4"; 4: s = "R1 R3"; 5: s = "R1 R4"; 6: s = "R1 R5";
      default: s = "R2";
    endcase
    if (t < SC) s = {s, " R10"};
    return s;
  endfunction

  function automatic string stat_tag(input int m);
    string s;
    case (m)
      3: s = "R6"; 7: s = "R7"; 4, 5: s = "R8"; default: s = "R9";
    endcase
    if (t < SC) s = {s, " R10"};
    return s;
  endfunction

  task automatic compare();
    int s;
    logic win, es, et;
    s   = (cur == 4) ? (t / SC) % FS : (t / SC) % FR;
    win = 1'b0; es = 1'b0; et = 1'b0;
    case (cur)
      3: begin win = (s < PON); es = ((t / PH) % 2) == 0; end
      4: begin win = (s != FS - 1); es = 1'b1; et = (s == FS - 1); end
      5: begin win = (s < PON); es = 1'b1; end
      6: win = (s < MON);
      7: es = ((t / FH) % 2) == 0;
      default: ;
    endcase
    chk(gate_tag(cur), gate_n, !(win && sense_low));
    chk(stat_tag(cur), status, es);
    chk("R3 strobe", test_win, et);
  endtask

  task automatic run(input int m, input int n, input int pat);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (m != cur) begin cur = m; t = 0; end
      mode = 3'(m);
      sense_low = (pat == 0) ? 1'b0 : (pat == 1) ? 1'b1 : ((k % 3) != 0);
      #2;
      compare();
      @(posedge clk);
      t++;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: outputs held inactive in reset even with fast mode and comparator low
    sense_low = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 gate", gate_n, 1'b1);
    chk("R11 status", status, 1'b0);
    chk("R11 strobe", test_win, 1'b0);
    @(negedge clk);
    mode = 3'd0; rst_n = 1'b1; cur = 0; t = 0;
    @(posedge clk); t++;
    run(0, 10, 1);
    run(2, 10, 1);
    run(3, 100, 2);   // ends inside a closed precharge slot
    run(5, 300, 2);   // R10: top-off starts with an open window at once
    run(4, 270, 2);
    run(4, 60, 1);
    run(4, 20, 0);
    run(6, 560, 1);
    run(7, 30, 1);
    run(1, 10, 1);
    run(2, 10, 1);
    run(3, 40, 0);
    run(7, 10, 1);
    run(3, 20, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule